// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Byte-Wide Readout

This block is the digital controller for a 12-bit-plus-sign successive-approximation converter that sits on an 8-bit microprocessor bus. A write strobe, qualified by chip select, starts a conversion. The sequencer then tests one bit of a trial word at a time, from the sign decision down to the least significant bit. The trial word drives an external DAC, and an external comparator reports back on one input bit. The whole conversion takes a fixed number of clock periods. When it ends, the 13-bit two's-complement result is latched, busy drops and an interrupt flag rises.

The host reads the result as two bytes, the high byte first. The high byte carries the five top result bits, and its remaining upper bits repeat the sign. The second read returns the low eight bits. Outside a read, the data bus is not driven: an output-enable signal is low and the data lines are held at zero. A read or a write, each qualified by chip select, clears the interrupt flag.

Top module: `sar_bus_seq`

## Requirements
- R1: During a clock with `rst_n` low, the block is reset synchronously: `busy`=0, `irq`=0, the byte pointer selects the high byte, and the stored result is 0.
- R2: A clock edge with `sel`=1 and `wr_stb`=1 starts a conversion, and `busy` is 1 from that edge on.
- R3: `irq` rises and `busy` falls exactly CONV_CYCLES (default 108) clock edges after the start edge.
- R4: The comparator input `cmp_in`=1 means the analog input is at or above the trial level on `dac_word`. The trial word is offset binary: bit 12 is tested first, then bits 11 down to 0. A trial bit is kept when `cmp_in` is 1. The stored result is the final trial word with bit 12 inverted, so it equals the input in 13-bit two's complement.
- R5: A clock edge with `sel`=1 and either `rd_stb` or `wr_stb` high clears `irq`, unless that same edge completes a conversion.
- R6: The first read after a conversion returns the high byte {result[12], result[12], result[12], result[12:8]}. The next read returns result[7:0].
- R7: The byte pointer toggles at the end of each read, so a third read returns the high byte again. The completion of a conversion forces the pointer back to the high byte.
- R8: `data_oe` is 1 only while `sel` and `rd_stb` are both 1. Whenever `data_oe` is 0, `data_out` is 8'h00.
- R9: A start during a conversion restarts it from the beginning. `irq` then rises CONV_CYCLES edges after the newer start.
- R10: The stored result changes only when a conversion completes, so a read during a conversion returns the previous result.
- R11: `wr_stb` and `rd_stb` have no effect while `sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| wr_stb | input | 1 | Write strobe: starts or restarts a conversion |
| rd_stb | input | 1 | Read strobe: level, one byte per assertion |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| dac_word | output | 13 | Offset-binary trial word for the DAC |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Conversion complete, cleared by read or write |
| data_out | output | 8 | Result byte, zero when not enabled |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bench drives its inputs and samples the outputs on falling clock edges. A start is therefore seen at the rising edge after the strobe is applied, and `busy` is checked at the very next falling edge. `irq` is checked low 107 falling edges after that point and high one edge later, which pins the completion to the exact edge. Read data is combinational from the stored result and the pointer, so it is sampled 2 ns after the read strobe is applied. The effect of a read on the interrupt flag and on the pointer appears only after the following rising edges, and it is checked at the next falling edge and on the next read.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W  = 13;
  localparam int BYTE_W = 8;
  localparam int EXT_W  = 2 * BYTE_W;

  // Offset-binary trial word to two's complement: invert the top bit.
  function automatic logic [RES_W-1:0] ob_to_tc(input logic [RES_W-1:0] ob);
    return {~ob[RES_W-1], ob[RES_W-2:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(input logic [RES_W-1:0] r);
    logic [EXT_W-1:0] ext;
    ext = {{(EXT_W-RES_W){r[RES_W-1]}}, r};
    return ext[EXT_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lo_byte(input logic [RES_W-1:0] r);
    return r[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int CONV_CYCLES = 108,
  parameter int BIT_CLKS    = 8,
  parameter int NBITS       = 13,
  localparam int IW         = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          decide,
  output logic [IW-1:0] bit_idx
);
  localparam int TRIAL = NBITS * BIT_CLKS;
  localparam int CW    = $clog2(CONV_CYCLES);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(CONV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done    = busy && !start && last;
  assign decide  = busy && !start && (int'(cnt) < TRIAL) &&
                   ((int'(cnt) % BIT_CLKS) == BIT_CLKS - 1);
  assign bit_idx = IW'(NBITS - 1 - int'(cnt) / BIT_CLKS);
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int NBITS = 13,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             decide,
  input  logic [IW-1:0]    bit_idx,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial
);
  logic [NBITS-1:0] nxt;

  always_comb begin
    nxt = trial;
    if (!cmp_in) nxt[bit_idx] = 1'b0;
    if (bit_idx != '0) nxt[bit_idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      trial <= '0;
    else if (start)  trial <= {1'b1, {(NBITS-1){1'b0}}};
    else if (decide) trial <= nxt;
  end
endmodule

// File: rtl/sar_readout.sv
module sar_readout
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              done,
  input  logic [RES_W-1:0]  result,
  output logic              hi_sel,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_oe
);
  logic ptr_lo;
  logic rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (done)                 ptr_lo <= 1'b0;
      else if (rd_q && !rd_act) ptr_lo <= ~ptr_lo;
    end
  end

  assign hi_sel   = !ptr_lo;
  assign data_oe  = rd_act;
  assign data_out = !rd_act ? '0 : (ptr_lo ? lo_byte(result) : hi_byte(result));
endmodule

// File: rtl/sar_bus_seq.sv
module sar_bus_seq
  import sar_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 108,
  parameter int BIT_CLKS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_word,
  output logic              busy,
  output logic              irq,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_oe
);
  localparam int IW = $clog2(RES_W);

  logic             start;
  logic             rd_act;
  logic             done;
  logic             decide;
  logic [IW-1:0]    bit_idx;
  logic [RES_W-1:0] result;
  logic             hi_sel;

  assign start  = sel && wr_stb;
  assign rd_act = sel && rd_stb;

  sar_timer #(.CONV_CYCLES(CONV_CYCLES), .BIT_CLKS(BIT_CLKS), .NBITS(RES_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .decide(decide), .bit_idx(bit_idx)
  );

  sar_trial #(.NBITS(RES_W)) u_trial (
    .clk(clk), .rst_n(rst_n), .start(start), .decide(decide),
    .bit_idx(bit_idx), .cmp_in(cmp_in), .trial(dac_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      result <= '0;
    end else begin
      if (done) begin
        irq    <= 1'b1;
        result <= ob_to_tc(dac_word);
      end else if (start || rd_act) begin
        irq <= 1'b0;
      end
    end
  end

  sar_readout u_rd (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .done(done), .result(result),
    .hi_sel(hi_sel), .data_out(data_out), .data_oe(data_oe)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int CONV_CYCLES = 108
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rd_act,
  input logic        done,
  input logic        busy,
  input logic        irq,
  input logic [12:0] result,
  input logic        hi_sel,
  input logic [7:0]  data_out,
  input logic        data_oe
);
  localparam int LW = $clog2(CONV_CYCLES + 1);
  logic [LW-1:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n)     len <= '0;
    else if (start) len <= '0;
    else if (busy && len != LW'(CONV_CYCLES)) len <= len + 1'b1;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R3
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len == LW'(CONV_CYCLES - 1)));
  // R3
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(irq));
  // R5
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((start || rd_act) && !done) |=> !irq);
  // R8
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == 8'h00));
  // R6
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && hi_sel) |-> (data_out[7:5] == {3{result[12]}}));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));
endmodule

bind sar_bus_seq sar_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_act(rd_act), .done(done),
  .busy(busy), .irq(irq), .result(result), .hi_sel(hi_sel),
  .data_out(data_out), .data_oe(data_oe)
);

// File: tb/tb_sar_bus_seq.sv
module tb_sar_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic        cmp_in;
  logic [12:0] dac_word;
  logic        busy, irq, data_oe;
  logic [7:0]  data_out;
  logic [12:0] target = 13'h0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  // Comparator model: input as offset binary, compared with the trial level
  assign cmp_in = ({~target[12], target[11:0]} >= dac_word);

  sar_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .cmp_in(cmp_in), .dac_word(dac_word), .busy(busy), .irq(irq),
    .data_out(data_out), .data_oe(data_oe)
  );

  localparam logic [12:0] VEC [8] = '{13'h0000, 13'h0001, 13'h1FFF, 13'h0FFF,
                                      13'h1000, 13'h0AAA, 13'h1555, 13'h0123};

  function automatic logic [7:0] exp_byte(input logic [12:0] t, input bit hi);
    int v;
    logic [15:0] w;
    v = t[12] ? int'(t) - 8192 : int'(t);
    w = 16'(v);
    return hi ? w[15:8] : w[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write();
    @(negedge clk); sel = 1'b1; wr_stb = 1'b1;
    @(negedge clk); sel = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] d);
    logic oe;
    @(negedge clk); sel = 1'b1; rd_stb = 1'b1;
    #2; d = data_out; oe = data_oe;
    check("R8 oe during read", 32'(oe), 32'd1);
    @(negedge clk); sel = 1'b0; rd_stb = 1'b0;
    #2;
    check("R8 oe after read", 32'(data_oe), 32'd0);
    check("R8 data zero after read", 32'(data_out), 32'd0);
  endtask

  task automatic run_conv(input logic [12:0] t);
    target = t;
    do_write();
    check("R2 busy after start", 32'(busy), 32'd1);
    repeat (107) @(negedge clk);
    check("R3 irq low one edge early", 32'(irq), 32'd0);
    @(negedge clk);
    check("R3 irq at completion", 32'(irq), 32'd1);
    check("R3 busy low at completion", 32'(busy), 32'd0);
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 200; k++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R8 oe idle", 32'(data_oe), 32'd0);
    do_read(d);
    check("R1 result zero, high byte", 32'(d), 32'd0);
    do_read(d); // restore pointer to high byte

    // Vector table: R4 R6 R7 R5
    for (int i = 0; i < 8; i++) begin
      run_conv(VEC[i]);
      do_read(d);
      check("R6 R4 high byte", 32'(d), 32'(exp_byte(VEC[i], 1'b1)));
      check("R5 read clears irq", 32'(irq), 32'd0);
      do_read(d);
      check("R6 R4 low byte", 32'(d), 32'(exp_byte(VEC[i], 1'b0)));
      do_read(d);
      check("R7 third read high byte", 32'(d), 32'(exp_byte(VEC[i], 1'b1)));
    end

    // R11: strobes without select
    @(negedge clk); wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    check("R11 write without sel", 32'(busy), 32'd0);
    @(negedge clk); rd_stb = 1'b1;
    #2;
    check("R11 read without sel oe", 32'(data_oe), 32'd0);
    check("R11 read without sel data", 32'(data_out), 32'd0);
    @(negedge clk); rd_stb = 1'b0;

    // R7: completion resets pointer (pointer is at low byte now)
    run_conv(13'h00F0);
    do_read(d);
    check("R7 pointer reset by completion", 32'(d), 32'h00);

    // R10: read during conversion returns previous result (pointer at low)
    target = 13'h1234;
    do_write();
    repeat (20) @(negedge clk);
    do_read(d);
    check("R10 read during conversion", 32'(d), 32'hF0);
    wait_irq();
    check("R3 irq after mid read", 32'(irq), 32'd1);
    do_read(d);
    check("R4 negative high byte", 32'(d), 32'(exp_byte(13'h1234, 1'b1)));

    // R5: write clears irq
    run_conv(13'h0055);
    target = 13'h0066;
    do_write();
    check("R5 write clears irq", 32'(irq), 32'd0);
    wait_irq();

    // R9: restart during conversion
    target = 13'h0800;
    do_write();
    repeat (40) @(negedge clk);
    target = 13'h07FF;
    do_write();
    repeat (107) @(negedge clk);
    check("R9 irq low before restarted end", 32'(irq), 32'd0);
    @(negedge clk);
    check("R9 irq at restarted end", 32'(irq), 32'd1);
    do_read(d);
    check("R9 high byte", 32'(d), 32'(exp_byte(13'h07FF, 1'b1)));
    do_read(d);
    check("R9 low byte", 32'(d), 32'(exp_byte(13'h07FF, 1'b0)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule